// File: doc/BRIEF.md
# Auto-Modify Register Undo Log

This block keeps a short history of the base-register adjustments that post-increment and pre-decrement operand modes apply while one instruction executes. The address generator reports each adjustment as a record holding a 3-bit register number and a signed 4-bit step. If a later memory access in the same instruction faults, the registers already hold their modified values. Recovery then hinges on putting them back before the instruction runs again from its start.

On a rollback request the block replays its records newest-first. Each record becomes one register-file write command per cycle, carrying the same register number and the two's-complement negation of the logged step. A one-cycle completion pulse follows the last command. An instruction-retire pulse empties the log at every instruction boundary. A third record within one instruction does not fit, so it raises a sticky overflow flag. The register file and fault detection sit outside the block.

Top module: `regmod_undo_log`

## Requirements
- R1: After synchronous reset, wr_valid_o, done_o, busy_o and overflow_o are 0 and the log is empty.
- R2: While idle, a record request with no rollback request in the same cycle stores the pair (rec_reg_i, rec_delta_i). Up to two records per instruction are kept.
- R3: A rollback request sampled while idle starts a replay. wr_valid_o is high in the cycles right after that edge, one cycle per stored record, with the newest record first.
- R4: Each write command carries the logged register number on wr_reg_o. wr_delta_o is the logged delta negated in 4-bit two's complement, so +2 (0010) gives 1110, +7 (0111) gives 1001, and -8 (1000) gives 1000.
- R5: done_o is a one-cycle pulse in the cycle after the last write command, or in the cycle right after the rollback sample when the log is empty. busy_o is high from the rollback sample until done_o, and no write command appears with done_o.
- R6: A completed rollback leaves the log empty, so a second rollback produces no write commands.
- R7: A retire pulse while idle, with no rollback request, empties the log and clears overflow_o. A record presented in the same cycle becomes the first entry of the next instruction.
- R8: A record arriving when two entries are already held is dropped and sets overflow_o. The flag stays set until a retire or reset.
- R9: When a record request and a rollback request arrive in the same cycle, rollback wins and the record is dropped.
- R10: While busy_o is high, record, retire and rollback requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction boundary: empty the log |
| rec_valid_i | input | 1 | Record a base-register adjustment |
| rec_reg_i | input | 3 | Register number of the adjustment |
| rec_delta_i | input | 4 | Signed step applied to the register |
| rollback_i | input | 1 | Fault: replay inverse adjustments |
| wr_valid_o | output | 1 | Register-file write command valid |
| wr_reg_o | output | 3 | Register to adjust |
| wr_delta_o | output | 4 | Signed step to add (inverse of logged step) |
| done_o | output | 1 | One-cycle pulse: rollback finished |
| busy_o | output | 1 | Replay in progress |
| overflow_o | output | 1 | Sticky: a third record arrived in one instruction |

## Verification
Replays are run with zero, one, two and three records. This shows that the order is newest-first, that the empty-log path pulses done_o at once, and that a surplus record is dropped rather than replayed. Delta values include positive and negative steps plus the edges +7 and -8, which separates true two's-complement negation from sign-flip or magnitude errors. Records issued together with retire, together with rollback, and during a replay show which request takes priority. The replayed register numbers tell whether memory slot 0 was overwritten when it should not have been.

// File: rtl/undo_log_pkg.sv
package undo_log_pkg;
  localparam int DEF_REG_W   = 3;
  localparam int DEF_DELTA_W = 4;
  localparam int DEF_DEPTH   = 2;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_REPLAY = 1'b1
  } phase_e;
endpackage

// File: rtl/undo_log_store.sv
module undo_log_store #(
  parameter int REG_W   = 3,
  parameter int DELTA_W = 4,
  parameter int DEPTH   = 2,
  parameter int CW      = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push_i,
  input  logic               retire_i,
  input  logic               restart_i,
  input  logic [REG_W-1:0]   rec_reg_i,
  input  logic [DELTA_W-1:0] rec_delta_i,
  input  logic [CW-1:0]      rd_idx_i,
  output logic [CW-1:0]      count_o,
  output logic               ovf_o,
  output logic [REG_W-1:0]   rd_reg_o,
  output logic [DELTA_W-1:0] rd_delta_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [REG_W-1:0]   reg_mem [DEPTH];
  logic [DELTA_W-1:0] dlt_mem [DEPTH];
  logic [CW-1:0]      cnt;
  logic               ovf;
  logic               has_room;
  logic               we;
  logic [CW-1:0]      waddr;

  always_comb begin
    has_room = (cnt < FULL);
    waddr    = retire_i ? '0 : cnt;
    we       = push_i && !restart_i && (retire_i || has_room);
  end

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we) begin
      reg_mem[IW'(waddr)] <= rec_reg_i;
      dlt_mem[IW'(waddr)] <= rec_delta_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (restart_i)     cnt <= '0;
      else if (retire_i) cnt <= push_i ? CW'(1) : '0;
      else if (we)       cnt <= cnt + CW'(1);

      if (retire_i)                                 ovf <= 1'b0;
      else if (push_i && !has_room && !restart_i)   ovf <= 1'b1;
    end
  end

  assign count_o    = cnt;
  assign ovf_o      = ovf;
  assign rd_reg_o   = reg_mem[IW'(rd_idx_i)];
  assign rd_delta_o = dlt_mem[IW'(rd_idx_i)];
endmodule

// File: rtl/undo_log_replay.sv
module undo_log_replay
  import undo_log_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int DELTA_W = 4,
  parameter int CW      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [CW-1:0]      count_i,
  input  logic [REG_W-1:0]   rd_reg_i,
  input  logic [DELTA_W-1:0] rd_delta_i,
  output logic [CW-1:0]      rd_idx_o,
  output logic               finish_o,
  output logic               busy_o,
  output logic               wr_valid_o,
  output logic [REG_W-1:0]   wr_reg_o,
  output logic [DELTA_W-1:0] wr_delta_o,
  output logic               done_o
);
  phase_e        ph;
  logic [CW-1:0] left;
  logic          first;
  logic          step;

  always_comb begin
    first    = (ph == PH_IDLE) && start_i && (count_i != '0);
    step     = (ph == PH_REPLAY) && (left != '0);
    finish_o = ((ph == PH_REPLAY) && (left == '0)) ||
               ((ph == PH_IDLE) && start_i && (count_i == '0));
    rd_idx_o = (ph == PH_IDLE) ? count_i - CW'(1) : left - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      left       <= '0;
      wr_valid_o <= 1'b0;
      wr_reg_o   <= '0;
      wr_delta_o <= '0;
      done_o     <= 1'b0;
    end else begin
      wr_valid_o <= first || step;
      done_o     <= finish_o;
      if (first || step) begin
        wr_reg_o   <= rd_reg_i;
        wr_delta_o <= DELTA_W'(0) - rd_delta_i;
        left       <= rd_idx_o;
      end
      if (first)         ph <= PH_REPLAY;
      else if (finish_o) ph <= PH_IDLE;
    end
  end

  assign busy_o = (ph == PH_REPLAY);
endmodule

// File: rtl/regmod_undo_log.sv
module regmod_undo_log
  import undo_log_pkg::*;
#(
  parameter int REG_W   = DEF_REG_W,
  parameter int DELTA_W = DEF_DELTA_W,
  parameter int DEPTH   = DEF_DEPTH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               retire_i,
  input  logic               rec_valid_i,
  input  logic [REG_W-1:0]   rec_reg_i,
  input  logic [DELTA_W-1:0] rec_delta_i,
  input  logic               rollback_i,
  output logic               wr_valid_o,
  output logic [REG_W-1:0]   wr_reg_o,
  output logic [DELTA_W-1:0] wr_delta_o,
  output logic               done_o,
  output logic               busy_o,
  output logic               overflow_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic               push;
  logic               retire_ok;
  logic               start;
  logic               finish;
  logic [CW-1:0]      count;
  logic [CW-1:0]      rd_idx;
  logic [REG_W-1:0]   rd_reg;
  logic [DELTA_W-1:0] rd_delta;
  logic               busy;

  // Rollback outranks record and retire; a replay blocks all three
  always_comb begin
    start     = rollback_i && !busy;
    push      = rec_valid_i && !busy && !rollback_i;
    retire_ok = retire_i && !busy && !rollback_i;
  end

  undo_log_store #(
    .REG_W(REG_W), .DELTA_W(DELTA_W), .DEPTH(DEPTH), .CW(CW)
  ) store_i (
    .clk(clk), .rst(rst),
    .push_i(push), .retire_i(retire_ok), .restart_i(finish),
    .rec_reg_i(rec_reg_i), .rec_delta_i(rec_delta_i),
    .rd_idx_i(rd_idx), .count_o(count), .ovf_o(overflow_o),
    .rd_reg_o(rd_reg), .rd_delta_o(rd_delta)
  );

  undo_log_replay #(
    .REG_W(REG_W), .DELTA_W(DELTA_W), .CW(CW)
  ) replay_i (
    .clk(clk), .rst(rst),
    .start_i(start), .count_i(count),
    .rd_reg_i(rd_reg), .rd_delta_i(rd_delta),
    .rd_idx_o(rd_idx), .finish_o(finish), .busy_o(busy),
    .wr_valid_o(wr_valid_o), .wr_reg_o(wr_reg_o),
    .wr_delta_o(wr_delta_o), .done_o(done_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/undo_log_chk.sv
module undo_log_chk (
  input logic clk,
  input logic rst,
  input logic retire_i,
  input logic rec_valid_i,
  input logic rollback_i,
  input logic wr_valid_o,
  input logic done_o,
  input logic busy_o,
  input logic overflow_o
);
  AST_WR_IN_REPLAY: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> busy_o); // R3

  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!wr_valid_o && !busy_o)); // R5

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o); // R5

  AST_START_REPLAY: assert property (@(posedge clk) disable iff (rst)
    (rollback_i && !busy_o) |=> (busy_o || done_o)); // R3

  AST_ROLLBACK_WINS: assert property (@(posedge clk) disable iff (rst)
    (rollback_i && rec_valid_i && !busy_o && !overflow_o) |=> !overflow_o); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !retire_i) |=> overflow_o); // R8

  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !busy_o && !rollback_i) |=> !overflow_o); // R7

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !overflow_o) |=> !overflow_o); // R10
endmodule

bind regmod_undo_log undo_log_chk chk_i (
  .clk(clk), .rst(rst), .retire_i(retire_i), .rec_valid_i(rec_valid_i),
  .rollback_i(rollback_i), .wr_valid_o(wr_valid_o), .done_o(done_o),
  .busy_o(busy_o), .overflow_o(overflow_o)
);

// File: tb/regmod_undo_log_tb_top.sv
`timescale 1ns/1ps
module regmod_undo_log_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       retire_i, rec_valid_i, rollback_i;
  logic [2:0] rec_reg_i;
  logic [3:0] rec_delta_i;
  logic       wr_valid_o, done_o, busy_o, overflow_o;
  logic [2:0] wr_reg_o;
  logic [3:0] wr_delta_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_r [2];
  logic [3:0] exp_d [2];

  always #4 clk = ~clk;

  regmod_undo_log dut_i (
    .clk(clk), .rst(rst), .retire_i(retire_i), .rec_valid_i(rec_valid_i),
    .rec_reg_i(rec_reg_i), .rec_delta_i(rec_delta_i), .rollback_i(rollback_i),
    .wr_valid_o(wr_valid_o), .wr_reg_o(wr_reg_o), .wr_delta_o(wr_delta_o),
    .done_o(done_o), .busy_o(busy_o), .overflow_o(overflow_o)
  );

  // {count[1:0], third{reg,delta}, second{reg,delta}, first{reg,delta}}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 7'd0,           7'd0,            7'd0},
    {2'd1, 7'd0,           7'd0,            {3'd5, 4'h2}},
    {2'd2, 7'd0,           {3'd6, 4'hF},    {3'd1, 4'h4}},
    {2'd2, 7'd0,           {3'd3, 4'h8},    {3'd3, 4'h7}},
    {2'd3, {3'd7, 4'h4},   {3'd4, 4'hE},    {3'd2, 4'h1}},
    {2'd1, 7'd0,           7'd0,            {3'd0, 4'hC}}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rec(logic [2:0] r, logic [3:0] d);
    @(negedge clk);
    rec_valid_i = 1'b1; rec_reg_i = r; rec_delta_i = d;
    @(negedge clk);
    rec_valid_i = 1'b0;
  endtask

  task automatic retire();
    @(negedge clk); retire_i = 1'b1;
    @(negedge clk); retire_i = 1'b0;
  endtask

  // Replay n writes from exp_r/exp_d, then the done pulse
  task automatic rollback_check(int n, string req);
    @(negedge clk); rollback_i = 1'b1;
    @(negedge clk); rollback_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk({req, " wr_valid"}, int'(wr_valid_o), 1);
      chk({req, " wr_reg"},   int'(wr_reg_o),   int'(exp_r[i]));
      chk({req, " wr_delta"}, int'(wr_delta_o), int'(exp_d[i]));
      chk({req, " busy"},     int'(busy_o),     1);
      @(negedge clk);
    end
    chk({req, " R5 done"},     int'(done_o),     1);
    chk({req, " R5 no write"}, int'(wr_valid_o), 0);
    @(negedge clk);
    chk({req, " R5 done pulse"}, int'(done_o), 0);
    chk({req, " R5 idle"},       int'(busy_o), 0);
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; retire_i = 1'b0; rec_valid_i = 1'b0; rollback_i = 1'b0;
    rec_reg_i = '0; rec_delta_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 wr_valid", int'(wr_valid_o), 0);
    chk("R1 done",     int'(done_o),     0);
    chk("R1 busy",     int'(busy_o),     0);
    chk("R1 overflow", int'(overflow_o), 0);
    rollback_check(0, "R1 empty log");

    // R2 R3 R4 R8 table walk
    for (int v = 0; v < NV; v++) begin
      int n;
      int k;
      logic [6:0] slot [3];
      n = int'(VEC[v][22:21]);
      slot[0] = VEC[v][6:0]; slot[1] = VEC[v][13:7]; slot[2] = VEC[v][20:14];
      retire();
      for (int j = 0; j < n; j++) rec(slot[j][6:4], slot[j][3:0]);
      k = (n > 2) ? 2 : n;
      for (int i = 0; i < k; i++) begin
        exp_r[i] = slot[k-1-i][6:4];
        exp_d[i] = 4'd0 - slot[k-1-i][3:0];
      end
      chk("R8 overflow", int'(overflow_o), (n > 2) ? 1 : 0);
      rollback_check(k, "R2 R3 R4 replay");
      chk("R8 overflow held", int'(overflow_o), (n > 2) ? 1 : 0);
      rollback_check(0, "R6 emptied");
    end

    // R7 retire clears overflow; same-cycle record starts the new log
    retire();
    rec(3'd1, 4'h1); rec(3'd2, 4'h1); rec(3'd3, 4'h1);
    chk("R8 set", int'(overflow_o), 1);
    @(negedge clk);
    retire_i = 1'b1; rec_valid_i = 1'b1; rec_reg_i = 3'd2; rec_delta_i = 4'h2;
    @(negedge clk);
    retire_i = 1'b0; rec_valid_i = 1'b0;
    chk("R7 overflow cleared", int'(overflow_o), 0);
    exp_r[0] = 3'd2; exp_d[0] = 4'hE;
    rollback_check(1, "R7 retire+record");

    // R9 rollback wins over a same-cycle record
    retire();
    rec(3'd3, 4'h1);
    @(negedge clk);
    rollback_i = 1'b1; rec_valid_i = 1'b1; rec_reg_i = 3'd5; rec_delta_i = 4'h2;
    @(negedge clk);
    rollback_i = 1'b0; rec_valid_i = 1'b0;
    chk("R9 wr_valid", int'(wr_valid_o), 1);
    chk("R9 wr_reg",   int'(wr_reg_o),   3);
    chk("R9 wr_delta", int'(wr_delta_o), 15);
    @(negedge clk);
    chk("R9 done", int'(done_o), 1);
    @(negedge clk);
    rollback_check(0, "R9 record dropped");

    // R10 inputs ignored during replay
    retire();
    rec(3'd1, 4'h1); rec(3'd2, 4'h2);
    @(negedge clk); rollback_i = 1'b1;
    @(negedge clk); rollback_i = 1'b0;
    chk("R10 first reg", int'(wr_reg_o), 2);
    rec_valid_i = 1'b1; retire_i = 1'b1; rollback_i = 1'b1;
    rec_reg_i = 3'd7; rec_delta_i = 4'h3;
    @(negedge clk);
    chk("R10 second reg",   int'(wr_reg_o),   1);
    chk("R10 second delta", int'(wr_delta_o), 15);
    @(negedge clk);
    chk("R10 done", int'(done_o), 1);
    rec_valid_i = 1'b0; retire_i = 1'b0; rollback_i = 1'b0;
    chk("R10 overflow", int'(overflow_o), 0);
    @(negedge clk);
    chk("R10 no second done", int'(done_o), 0);
    rollback_check(0, "R10 nothing recorded");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule